// File: doc/BRIEF.md
# Management Serial Frame Receiver with Switchable Preamble

This block is the slave side of a two-wire management link. It watches a management clock input and a serial data input, takes one data bit at each rising edge of the management clock, and decodes frames of the common clause-22 shape. A frame names a device address, a register address and an operation. The operation is either a write of 16 bits or a read of 16 bits. On a read, the block drives the data line back through an output value and a separate output-enable. The pad that merges these with the input is not part of this block.

A run-time control bit chooses how strict the block is about what comes before a frame. When the bit is set, a frame counts only if an unbroken run of at least 32 ones comes just before its start pattern. When the bit is clear, a frame is taken whether or not such a run is present, so a host can send frames back to back. A read-only status bit shows the inverse of the effective setting. A compatibility input freezes the control bit while it is high and also disables it. The rest of the register set is a few plain read/write words, which give the read and write paths something to work on.

Everything runs on one system clock. The management clock is treated as a slow input that is already synchronous to it, and a rising edge is recognised on the first system clock edge at which it is seen high after having been low.

Top module: `mdio_slave`

## Requirements
- R1: After reset the output-enable is 0, the preamble-required bit is 0, the status bit reads 1 and every scratch word is 0.
- R2: A frame is a 0 and then a 1 (start), a 2-bit opcode (10 read, 01 write), a 5-bit device address, a 5-bit register address, 2 turnaround bits and 16 data bits. Every field is sent MSB first. A bit is taken at the system clock edge where a management clock rise is first seen. On a write to this device, the data is stored when the last data bit is taken.
- R3: On a read to this device the output-enable stays 0 through the first turnaround bit. At the edge that takes that bit, the block enables the output with value 0. At the edge that takes the second turnaround bit, it presents data bit 15. It then moves on one bit per rise, and it releases the output at the edge that takes the last data bit. The output-enable changes only at edges where a management clock rise is taken.
- R4: A frame whose device address differs from the address input is ignored: the output is never enabled for it and no register changes.
- R5: A frame with opcode 00 or 11 is ignored: the output is never enabled for it and no register changes.
- R6: The configuration register, at address 0x11, holds the preamble-required bit in bit 0. It is readable and writable, its other bits read 0, and it resets to 0.
- R7: The status register, at address 0x01, reads the inverse of the effective preamble requirement in bit 0 and 0 in its other bits. Writes to it have no effect.
- R8: While the effective requirement is 1, a start is accepted only if at least 32 consecutive ones were taken since the end of the previous frame, immediately before the start 0. Otherwise the whole frame is discarded: no drive, no register change.
- R9: While the effective requirement is 0, a 0 followed by a 1 taken while idle starts a frame, including straight after the previous frame's last bit.
- R10: While the compatibility input is 1, writes to the preamble-required bit are ignored and the effective requirement is 0. When the input returns to 0, the stored bit applies again.
- R11: Four 16-bit scratch words at addresses 0x18 to 0x1B can be read and written. Other addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock, sampled on clk |
| mdioIn | input | 1 | Serial management data from the line |
| phyAddr | input | 5 | Device address this slave answers to |
| compatLock | input | 1 | Freezes and disables the preamble-required bit |
| mdioOut | output | 1 | Value driven onto the data line during reads |
| mdioOe | output | 1 | Output-enable for the data line |

## Verification
The bench builds the block with its default parameters: 5-bit device and register addresses, 16-bit data, a 32-bit preamble length, and four scratch words at 0x18. With these values the preamble boundary can be exercised exactly, using runs of 31 and 32 ones. Frames of full width can be mixed back to back in the permissive mode, and the configuration, status, scratch and unmapped addresses all fall inside the reachable 5-bit space. A behavioural model built on a bit queue predicts the output-enable and the driven data at every system clock.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HDR,
    ST_TA1,
    ST_TA2,
    ST_DATA
  } mdioState_t;

  // strobes from control to datapath, all qualified by a management clock rise
  typedef struct packed {
    logic hdrShift;
    logic rdLoad;
    logic rdShift;
    logic wrShift;
    logic commit;
    logic oeSet;
    logic oeClr;
  } mdioStrobe_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mdio_slave_ctrl.sv
module mdio_slave_ctrl
  import mdio_slave_pkg::*;
#(
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mdc,
  input  logic             mdioIn,
  input  logic             effReq,
  input  logic [1:0]       hdrOp,
  input  logic [PHY_W-1:0] hdrPhy,
  input  logic [PHY_W-1:0] phyAddr,
  output mdioStrobe_t      strobe
);

  localparam int HDR_LEN = 2 + PHY_W + REG_W;
  localparam int CNT_MAX = (HDR_LEN > DATA_W) ? HDR_LEN : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int ONES_W  = $clog2(PRE_LEN + 1);

  mdioState_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [ONES_W-1:0] ones;
  logic              mdcPrev;
  logic              active;
  logic              isRead;
  logic              rise;
  logic              frameHit;
  logic              lastData;
  logic              preOk;

  assign rise     = mdc & ~mdcPrev;
  assign frameHit = (hdrPhy == phyAddr) && ((hdrOp == OP_READ) || (hdrOp == OP_WRITE));
  assign lastData = (cnt == CNT_W'(DATA_W - 1));
  assign preOk    = !effReq || (ones == ONES_W'(PRE_LEN));

  always_comb begin
    strobe = '0;
    if (rise) begin
      case (state)
        ST_HDR:  strobe.hdrShift = 1'b1;
        ST_TA1: begin
          if (frameHit && (hdrOp == OP_READ)) begin
            strobe.rdLoad = 1'b1;
            strobe.oeSet  = 1'b1;
          end
        end
        ST_TA2:  strobe.rdShift = active && isRead;
        ST_DATA: begin
          if (active && isRead) begin
            strobe.oeClr   = lastData;
            strobe.rdShift = !lastData;
          end else if (active) begin
            strobe.wrShift = 1'b1;
            strobe.commit  = lastData;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      ones    <= '0;
      mdcPrev <= 1'b0;
      active  <= 1'b0;
      isRead  <= 1'b0;
    end else begin
      mdcPrev <= mdc;
      if (rise) begin
        case (state)
          ST_IDLE: begin
            if (mdioIn) begin
              if (ones != ONES_W'(PRE_LEN)) ones <= ones + 1'b1;
            end else begin
              ones <= '0;
              if (preOk) state <= ST_START;
            end
          end
          ST_START: begin
            if (mdioIn) begin
              state <= ST_HDR;
              cnt   <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_HDR: begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(HDR_LEN - 1)) state <= ST_TA1;
          end
          ST_TA1: begin
            active <= frameHit;
            isRead <= (hdrOp == OP_READ);
            state  <= ST_TA2;
          end
          ST_TA2: begin
            cnt   <= '0;
            state <= ST_DATA;
          end
          ST_DATA: begin
            cnt <= cnt + 1'b1;
            if (lastData) begin
              state  <= ST_IDLE;
              ones   <= '0;
              active <= 1'b0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mdio_slave_dp.sv
module mdio_slave_dp
  import mdio_slave_pkg::*;
#(
  parameter int PHY_W        = 5,
  parameter int REG_W        = 5,
  parameter int DATA_W       = 16,
  parameter int CFG_ADDR     = 17,
  parameter int STAT_ADDR    = 1,
  parameter int SCRATCH_BASE = 24,
  parameter int SCRATCH_NUM  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdioStrobe_t      strobe,
  input  logic             bitIn,
  input  logic             compatLock,
  output logic [1:0]       hdrOp,
  output logic [PHY_W-1:0] hdrPhy,
  output logic             effReq,
  output logic             preReqOut,
  output logic             mdioOut,
  output logic             mdioOe
);

  localparam int HDR_LEN = 2 + PHY_W + REG_W;

  logic [HDR_LEN-1:0]            hdr;
  logic [REG_W-1:0]              hdrReg;
  logic [DATA_W-1:0]             rdSh;
  logic [DATA_W-1:0]             wrSh;
  logic [DATA_W-1:0]             wrWord;
  logic [DATA_W-1:0]             rdVal;
  logic [SCRATCH_NUM*DATA_W-1:0] scratchFlat;
  logic                          preReq;

  assign hdrReg    = hdr[REG_W-1:0];
  assign hdrPhy    = hdr[REG_W +: PHY_W];
  assign hdrOp     = hdr[HDR_LEN-1 -: 2];
  assign wrWord    = {wrSh[DATA_W-2:0], bitIn};
  assign effReq    = preReq & ~compatLock;
  assign preReqOut = preReq;

  always_comb begin
    rdVal = '0;
    if (hdrReg == REG_W'(CFG_ADDR)) begin
      rdVal[0] = preReq;
    end else if (hdrReg == REG_W'(STAT_ADDR)) begin
      rdVal[0] = ~effReq;
    end else begin
      for (int i = 0; i < SCRATCH_NUM; i++) begin
        if (hdrReg == REG_W'(SCRATCH_BASE + i)) rdVal = scratchFlat[i*DATA_W +: DATA_W];
      end
    end
  end

  for (genvar g = 0; g < SCRATCH_NUM; g++) begin : gScratch
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) word <= '0;
      else if (strobe.commit && (hdrReg == REG_W'(SCRATCH_BASE + g))) word <= wrWord;
    end
    assign scratchFlat[g*DATA_W +: DATA_W] = word;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdr     <= '0;
      rdSh    <= '0;
      wrSh    <= '0;
      preReq  <= 1'b0;
      mdioOut <= 1'b0;
      mdioOe  <= 1'b0;
    end else begin
      if (strobe.hdrShift) hdr <= {hdr[HDR_LEN-2:0], bitIn};
      if (strobe.wrShift) wrSh <= wrWord;
      if (strobe.commit && (hdrReg == REG_W'(CFG_ADDR)) && !compatLock) preReq <= wrWord[0];
      if (strobe.rdLoad) rdSh <= rdVal;
      if (strobe.oeSet) begin
        mdioOe  <= 1'b1;
        mdioOut <= 1'b0;
      end
      if (strobe.rdShift) begin
        mdioOut <= rdSh[DATA_W-1];
        rdSh    <= {rdSh[DATA_W-2:0], 1'b0};
      end
      if (strobe.oeClr) mdioOe <= 1'b0;
    end
  end

endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
  import mdio_slave_pkg::*;
#(
  parameter int PHY_W        = 5,
  parameter int REG_W        = 5,
  parameter int DATA_W       = 16,
  parameter int PRE_LEN      = 32,
  parameter int CFG_ADDR     = 17,
  parameter int STAT_ADDR    = 1,
  parameter int SCRATCH_BASE = 24,
  parameter int SCRATCH_NUM  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mdc,
  input  logic             mdioIn,
  input  logic [PHY_W-1:0] phyAddr,
  input  logic             compatLock,
  output logic             mdioOut,
  output logic             mdioOe
);

  mdioStrobe_t      ctrlStrobe;
  logic [1:0]       hdrOp;
  logic [PHY_W-1:0] hdrPhy;
  logic             effReq;
  logic             preReqBit;

  mdio_slave_ctrl #(
    .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .mdc(mdc), .mdioIn(mdioIn), .effReq(effReq),
    .hdrOp(hdrOp), .hdrPhy(hdrPhy), .phyAddr(phyAddr), .strobe(ctrlStrobe)
  );

  mdio_slave_dp #(
    .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR),
    .STAT_ADDR(STAT_ADDR), .SCRATCH_BASE(SCRATCH_BASE), .SCRATCH_NUM(SCRATCH_NUM)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(ctrlStrobe), .bitIn(mdioIn),
    .compatLock(compatLock), .hdrOp(hdrOp), .hdrPhy(hdrPhy), .effReq(effReq),
    .preReqOut(preReqBit), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

endmodule

// File: rtl/mdio_slave_chk.sv
module mdio_slave_chk (
  input logic clk,
  input logic rstN,
  input logic mdc,
  input logic mdioOe,
  input logic mdioOut,
  input logic compatLock,
  input logic preReqBit,
  input logic commitStb,
  input logic oeSetStb
);

  // R3: the enable only moves at an edge that took a management clock rise
  assert_oe_on_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdioOe) |-> $past(mdc));

  // R3: the first driven value after enabling is the turnaround zero
  assert_ta_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe) |-> !mdioOut);

  // R3: enabling only happens from the released state
  assert_oe_from_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    oeSetStb |-> !mdioOe);

  // R2: write data is stored while the line is not driven
  assert_commit_undriven_R2: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> !mdioOe);

  // R10: the lock freezes the preamble-required bit
  assert_lock_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    (compatLock && $past(compatLock)) |-> $stable(preReqBit));

endmodule

bind mdio_slave mdio_slave_chk uChk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOe(mdioOe), .mdioOut(mdioOut),
  .compatLock(compatLock), .preReqBit(preReqBit),
  .commitStb(ctrlStrobe.commit), .oeSetStb(ctrlStrobe.oeSet)
);

// File: tb/sim_mdio_slave.sv
module sim_mdio_slave;

  localparam bit [4:0] MY_PHY    = 5'h05;
  localparam bit [4:0] OTHER_PHY = 5'h06;
  localparam bit [4:0] A_CFG     = 5'h11;
  localparam bit [4:0] A_STAT    = 5'h01;
  localparam bit [4:0] A_SCR     = 5'h18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mdc = 1'b0;
  logic mdioIn = 1'b1;
  logic compatLock = 1'b0;
  logic mdioOut;
  logic mdioOe;

  int tests = 0;
  int fails = 0;
  string curReq = "R1";
  bit checking = 1'b0;
  bit oeSeen = 1'b0;
  bit lastSampled = 1'b0;

  // behavioural model state
  bit expOe = 1'b0;
  bit expOut = 1'b0;
  bit mPre = 1'b0;
  bit [15:0] mScr [4];
  int mPhase = 0;
  int mOnes = 0;
  bit mHit = 1'b0;
  bit mRd = 1'b0;
  bit [15:0] mWord = '0;
  bit [4:0] mReg = '0;
  bit q[$];

  always #10 clk = ~clk;

  mdio_slave u0 (
    .clk(clk), .rstN(rstN), .mdc(mdc), .mdioIn(mdioIn), .phyAddr(MY_PHY),
    .compatLock(compatLock), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit effNow();
    return mPre && !compatLock;
  endfunction

  function automatic bit [15:0] modelRead(input bit [4:0] a);
    if (a == A_CFG) return {15'b0, mPre};
    if (a == A_STAT) return {15'b0, !effNow()};
    if (a >= A_SCR && a < A_SCR + 5'd4) return mScr[a - A_SCR];
    return 16'h0;
  endfunction

  task automatic modelBit(input bit b);
    int k;
    int j;
    bit [15:0] w;
    bit [1:0] op;
    bit [4:0] phy;
    case (mPhase)
      0: begin
        if (b) begin
          if (mOnes < 32) mOnes++;
        end else begin
          if (!effNow() || mOnes >= 32) mPhase = 1;
          mOnes = 0;
        end
      end
      1: begin
        if (b) begin mPhase = 2; q.delete(); end
        else mPhase = 0;
      end
      default: begin
        q.push_back(b);
        k = q.size() - 1;
        if (k == 12) begin
          op = {q[0], q[1]};
          for (int i = 0; i < 5; i++) phy[4-i] = q[2+i];
          for (int i = 0; i < 5; i++) mReg[4-i] = q[7+i];
          mHit = (phy == MY_PHY) && (op == 2'b10 || op == 2'b01);
          mRd = (op == 2'b10);
          if (mHit && mRd) begin
            mWord = modelRead(mReg);
            expOe = 1'b1;
            expOut = 1'b0;
          end
        end else if (k == 13) begin
          if (mHit && mRd) expOut = mWord[15];
        end else if (k >= 14) begin
          j = k - 14;
          if (mHit && mRd) begin
            if (j < 15) expOut = mWord[14-j];
            else expOe = 1'b0;
          end
          if (j == 15) begin
            if (mHit && !mRd) begin
              for (int i = 0; i < 16; i++) w[15-i] = q[14+i];
              if (mReg == A_CFG) begin
                if (!compatLock) mPre = w[0];
              end else if (mReg >= A_SCR && mReg < A_SCR + 5'd4) begin
                mScr[mReg - A_SCR] = w;
              end
            end
            mPhase = 0;
            mOnes = 0;
          end
        end
      end
    endcase
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (checking && rstN) begin
      if (mdioOe) oeSeen = 1'b1;
      check(mdioOe == expOe, curReq, mdioOe, expOe, "mdioOe");
      if (expOe) check(mdioOut == expOut, curReq, mdioOut, expOut, "mdioOut");
    end
  end

  task automatic sendBit(input bit b);
    @(negedge clk); mdc = 1'b0; mdioIn = b;
    @(negedge clk);
    @(negedge clk); lastSampled = mdioOut; mdc = 1'b1;
    @(posedge clk); modelBit(b);
    @(negedge clk);
  endtask

  task automatic doFrame(input int pre, input bit [1:0] op, input bit [4:0] phy,
                         input bit [4:0] rg, input bit [15:0] wdata,
                         output bit [15:0] rdata, output bit sawOe);
    oeSeen = 1'b0;
    rdata = '0;
    for (int i = 0; i < pre; i++) sendBit(1'b1);
    sendBit(1'b0); sendBit(1'b1);
    for (int i = 1; i >= 0; i--) sendBit(op[i]);
    for (int i = 4; i >= 0; i--) sendBit(phy[i]);
    for (int i = 4; i >= 0; i--) sendBit(rg[i]);
    sendBit(1'b1);
    sendBit(op == 2'b01 ? 1'b0 : 1'b1);
    for (int i = 15; i >= 0; i--) begin
      sendBit(op == 2'b01 ? wdata[i] : 1'b1);
      rdata[i] = lastSampled;
    end
    sawOe = oeSeen;
  endtask

  task automatic wr(input int pre, input bit [4:0] phy, input bit [4:0] rg, input bit [15:0] d);
    bit [15:0] r;
    bit s;
    doFrame(pre, 2'b01, phy, rg, d, r, s);
  endtask

  task automatic rdChk(input int pre, input bit [4:0] rg, input bit [15:0] exp, input string req);
    bit [15:0] r;
    bit s;
    doFrame(pre, 2'b10, MY_PHY, rg, 16'h0, r, s);
    check(r == exp, req, r, exp, "read data");
  endtask

  task automatic noDrive(input int pre, input bit [1:0] op, input bit [4:0] phy, input bit [4:0] rg, input string req);
    bit [15:0] r;
    bit s;
    doFrame(pre, op, phy, rg, 16'h0, r, s);
    check(!s, req, s, 0, "line driven for ignored frame");
  endtask

  task automatic runAll();
    for (int i = 0; i < 4; i++) mScr[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checking = 1'b1;
    // R1: reset values
    check(mdioOe == 1'b0, "R1", mdioOe, 0, "oe after reset");
    curReq = "R1";
    rdChk(0, A_STAT, 16'h0001, "R1");
    rdChk(0, A_CFG, 16'h0000, "R1");
    rdChk(0, A_SCR + 5'd2, 16'h0000, "R1");
    // R2 R3 R9: write then read back, frames back to back without preamble
    curReq = "R3";
    wr(0, MY_PHY, A_SCR + 5'd1, 16'hBEEF);
    rdChk(0, A_SCR + 5'd1, 16'hBEEF, "R2");
    rdChk(0, A_SCR + 5'd1, 16'hBEEF, "R9");
    // R4: foreign device address
    curReq = "R4";
    wr(0, OTHER_PHY, A_SCR + 5'd1, 16'hDEAD);
    noDrive(0, 2'b10, OTHER_PHY, A_SCR + 5'd1, "R4");
    rdChk(0, A_SCR + 5'd1, 16'hBEEF, "R4");
    // R5: undefined opcodes
    curReq = "R5";
    begin
      bit [15:0] r;
      bit s;
      doFrame(0, 2'b11, MY_PHY, A_SCR + 5'd1, 16'h0F0F, r, s);
      check(!s, "R5", s, 0, "opcode 11 drove line");
      doFrame(0, 2'b00, MY_PHY, A_SCR + 5'd1, 16'h0F0F, r, s);
      check(!s, "R5", s, 0, "opcode 00 drove line");
    end
    rdChk(0, A_SCR + 5'd1, 16'hBEEF, "R5");
    // R11: unmapped address, other scratch words
    curReq = "R11";
    wr(0, MY_PHY, 5'h05, 16'h0101);
    rdChk(0, 5'h05, 16'h0000, "R11");
    wr(0, MY_PHY, A_SCR + 5'd3, 16'hC3A5);
    rdChk(0, A_SCR + 5'd3, 16'hC3A5, "R11");
    // R7: status write has no effect
    curReq = "R7";
    wr(0, MY_PHY, A_STAT, 16'h0000);
    rdChk(0, A_STAT, 16'h0001, "R7");
    // R6: set the preamble-required bit
    curReq = "R6";
    wr(0, MY_PHY, A_CFG, 16'hFFFF);
    rdChk(32, A_CFG, 16'h0001, "R6");
    rdChk(32, A_STAT, 16'h0000, "R7");
    // R8: required mode boundaries
    curReq = "R8";
    wr(32, MY_PHY, A_SCR, 16'hAAAA);
    wr(31, MY_PHY, A_SCR, 16'h1234);
    rdChk(32, A_SCR, 16'hAAAA, "R8");
    noDrive(0, 2'b10, MY_PHY, A_SCR, "R8");
    noDrive(0, 2'b10, MY_PHY, A_CFG, "R8");
    wr(0, MY_PHY, A_SCR, 16'h5555);
    rdChk(32, A_SCR, 16'hAAAA, "R8");
    // R10: compatibility lock
    curReq = "R10";
    @(negedge clk); compatLock = 1'b1;
    wr(32, MY_PHY, A_CFG, 16'h0000);
    rdChk(0, A_CFG, 16'h0001, "R10");
    rdChk(0, A_STAT, 16'h0001, "R10");
    wr(0, MY_PHY, A_SCR + 5'd2, 16'h7E81);
    rdChk(0, A_SCR + 5'd2, 16'h7E81, "R10");
    @(negedge clk); compatLock = 1'b0;
    noDrive(0, 2'b10, MY_PHY, A_CFG, "R10");
    // R9: clear the bit, permissive mode again
    curReq = "R9";
    wr(32, MY_PHY, A_CFG, 16'h0000);
    rdChk(0, A_CFG, 16'h0000, "R9");
    rdChk(0, A_STAT, 16'h0001, "R9");
    checking = 1'b0;
  endtask

  initial begin
    bit timedOut;
    timedOut = 1'b0;
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule